// File: doc/BRIEF.md
# Multiplexed LCD Frame Sequencer

This block produces the digital pin controls for a multiplexed segment LCD. It scans the display one common line at a time. For each common pin and each segment pin it gives a phase bit, an amplitude bit and an output-enable bit. An analog stage turns these bits into real voltages. Software loads segment data through a simple byte write port. The data is held in a bank of five bytes per common line. At the start of every frame the bank is copied into a shadow copy, so the picture on the glass never mixes two frames.

Time is set by an external `tick`. Each tick marks one voltage transition. Every common slot has two half-periods with opposite polarity, so each pin has a zero DC average. This holds in static mode too. After each transition a timer keeps the drivers on for a programmable time and then tri-states them. A bypass input keeps the drivers on all the time. When the duty uses more than one common line, the on-time is clamped to a supplied half-period limit. All enables stay low until the supply-ready input is asserted.

Top module: `lcd_frame_seq`

## Requirements
- R1: The first `tick` after reset starts a frame on common 0, half-period 0. Each later tick moves to the next half-period, and after the second half-period it moves to the next common. After the second half of common `duty` the next tick starts a new frame on common 0. The duty code is 0 for static, 1 for 1/2, 2 for 1/3 and 3 for 1/4.
- R2: The polarity `pol` is 0 in the first half-period of a slot and 1 in the second. The addressed common has amplitude 1 and phase `~pol`. Every other common has amplitude 0 and phase `pol`.
- R3: A segment whose data bit is 1 has amplitude 1 and phase `pol`. A segment whose bit is 0 has amplitude 0 and phase `~pol`.
- R4: While common c is addressed, segment n takes byte `c*5 + n/8`, bit `n%8`. Write address a (0 to 19) stores into byte a. Static mode therefore uses bytes 0 to 4 only.
- R5: The shadow copy is updated only at the frame-start tick. A write during a frame has no effect on the segment outputs until the next frame starts.
- R6: Starting in the cycle after a tick edge, every output enable is 1 for exactly 2^`drive_code` cycles and is then 0.
- R7: When `duty` is not 0, the on-time is min(2^`drive_code`, `half_period`). When `duty` is 0, no clamp is applied.
- R8: While `drive_bypass` is 1 and a frame is running, the enables stay at 1 between ticks.
- R9: While `supply_ok` is 0, every enable is 0.
- R10: Commons with an index above `duty` stay at the non-addressed level for the whole frame: amplitude 0, phase `pol`.
- R11: Synchronous reset clears the data bank and the shadow copy and stops the scan. Until the next tick all amplitudes, phases and enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 5 | Byte address, 0 to 19 |
| wr_data | input | 8 | Byte to store |
| tick | input | 1 | One-cycle transition pulse |
| duty | input | 2 | Number of commons minus one |
| drive_code | input | 3 | On-time code, 2^code cycles |
| drive_bypass | input | 1 | Keep drivers on for the whole period |
| half_period | input | 8 | On-time clamp in cycles for multi-common duty |
| supply_ok | input | 1 | LCD supply has reached its target |
| com_phase | output | 4 | Phase bit per common pin |
| com_amp | output | 4 | Amplitude bit per common pin |
| com_oe | output | 4 | Output enable per common pin |
| seg_phase | output | 40 | Phase bit per segment pin |
| seg_amp | output | 40 | Amplitude bit per segment pin |
| seg_oe | output | 40 | Output enable per segment pin |

## Verification
The bench walks a whole 1/4-duty frame and checks the wrap back to common 0. A sequencer that counts past the duty would address a fifth slot or leave common 0 silent. A write made mid-frame must stay invisible until the wrap; a bank without a shadow copy would show the new byte at once. The clamp is tested with a 128-cycle code against a 10-cycle limit, and again in static mode where the full 128 cycles must appear. Inverted polarity in the second half-period and idle unused commons at 1/2 duty catch encoders that drop the DC balance or drive pins that should be idle.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
    localparam int NUM_COM       = 4;
    localparam int BYTES_PER_COM = 5;
    localparam int SEG_PER_COM   = BYTES_PER_COM * 8;
    localparam int NUM_BYTES     = NUM_COM * BYTES_PER_COM;
    localparam int ADDR_W        = $clog2(NUM_BYTES);
    localparam int IDX_W         = $clog2(NUM_COM);
    localparam int DT_W          = 8;
    localparam int CODE_W        = 3;

    typedef enum logic [IDX_W-1:0] {
        DUTY_STATIC  = 2'd0,
        DUTY_HALF    = 2'd1,
        DUTY_THIRD   = 2'd2,
        DUTY_QUARTER = 2'd3
    } duty_e;

    typedef struct packed {
        logic             running;
        logic [IDX_W-1:0] com;
        logic             pol;
    } scan_t;

    // on-time for one transition, clamped when several commons share the frame
    function automatic logic [DT_W-1:0] drive_len(input logic [CODE_W-1:0] code,
                                                  input logic multi,
                                                  input logic [DT_W-1:0] cap);
        logic [DT_W-1:0] raw;
        raw = DT_W'(1) << code;
        if (multi && (raw > cap)) return cap;
        return raw;
    endfunction
endpackage

// File: rtl/lcd_shadow_bank.sv
module lcd_shadow_bank
    import lcd_seq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [7:0]             wr_data,
    input  logic                   latch,
    output logic [NUM_BYTES*8-1:0] shadow
);
    logic [7:0] live [NUM_BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_BYTES; i++) live[i] <= '0;
            shadow <= '0;
        end else begin
            if (wr_en && (wr_addr < ADDR_W'(NUM_BYTES)))
                live[wr_addr] <= wr_data;
            if (latch)
                for (int i = 0; i < NUM_BYTES; i++) shadow[i*8 +: 8] <= live[i];
        end
    end
endmodule

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
    import lcd_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [IDX_W-1:0] duty,
    output scan_t            st,
    output logic             frame_start
);
    logic at_last;

    always_comb begin
        at_last     = st.pol && (st.com >= duty);
        frame_start = tick && (!st.running || at_last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '{running: 1'b0, com: '0, pol: 1'b0};
        end else if (tick) begin
            if (frame_start)
                st <= '{running: 1'b1, com: '0, pol: 1'b0};
            else if (st.pol) begin
                st.com <= st.com + IDX_W'(1);
                st.pol <= 1'b0;
            end else
                st.pol <= 1'b1;
        end
    end
endmodule

// File: rtl/lcd_drive_timer.sv
module lcd_drive_timer
    import lcd_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [IDX_W-1:0]  duty,
    input  logic [CODE_W-1:0] drive_code,
    input  logic              drive_bypass,
    input  logic [DT_W-1:0]   half_period,
    input  logic              supply_ok,
    input  logic              running,
    output logic              drive
);
    logic [DT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (tick)
            remain <= drive_len(drive_code, duty != DUTY_STATIC, half_period);
        else if (remain != '0)
            remain <= remain - DT_W'(1);
    end

    assign drive = running && supply_ok && (drive_bypass || (remain != '0));
endmodule

// File: rtl/lcd_pin_encoder.sv
module lcd_pin_encoder
    import lcd_seq_pkg::*;
(
    input  scan_t                  st,
    input  logic [NUM_BYTES*8-1:0] shadow,
    output logic [NUM_COM-1:0]     com_phase,
    output logic [NUM_COM-1:0]     com_amp,
    output logic [SEG_PER_COM-1:0] seg_phase,
    output logic [SEG_PER_COM-1:0] seg_amp
);
    logic [SEG_PER_COM-1:0] grp;
    int                     base;

    always_comb begin
        base = int'(st.com) * SEG_PER_COM;
        grp  = shadow[base +: SEG_PER_COM];
        for (int c = 0; c < NUM_COM; c++) begin
            com_amp[c]   = st.running && (st.com == IDX_W'(c));
            com_phase[c] = st.running && (com_amp[c] ? !st.pol : st.pol);
        end
        seg_amp   = st.running ? grp : '0;
        seg_phase = st.running ? (st.pol ? grp : ~grp) : '0;
    end
endmodule

// File: rtl/lcd_frame_seq.sv
module lcd_frame_seq
    import lcd_seq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [7:0]             wr_data,
    input  logic                   tick,
    input  logic [IDX_W-1:0]       duty,
    input  logic [CODE_W-1:0]      drive_code,
    input  logic                   drive_bypass,
    input  logic [DT_W-1:0]        half_period,
    input  logic                   supply_ok,
    output logic [NUM_COM-1:0]     com_phase,
    output logic [NUM_COM-1:0]     com_amp,
    output logic [NUM_COM-1:0]     com_oe,
    output logic [SEG_PER_COM-1:0] seg_phase,
    output logic [SEG_PER_COM-1:0] seg_amp,
    output logic [SEG_PER_COM-1:0] seg_oe
);
    scan_t                  st;
    logic                   frame_start;
    logic                   drive;
    logic [NUM_BYTES*8-1:0] shadow;

    lcd_shadow_bank u_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .latch(frame_start), .shadow(shadow)
    );

    lcd_scan_ctrl u_scan (
        .clk(clk), .rst(rst), .tick(tick), .duty(duty),
        .st(st), .frame_start(frame_start)
    );

    lcd_drive_timer u_timer (
        .clk(clk), .rst(rst), .tick(tick), .duty(duty),
        .drive_code(drive_code), .drive_bypass(drive_bypass),
        .half_period(half_period), .supply_ok(supply_ok),
        .running(st.running), .drive(drive)
    );

    lcd_pin_encoder u_enc (
        .st(st), .shadow(shadow),
        .com_phase(com_phase), .com_amp(com_amp),
        .seg_phase(seg_phase), .seg_amp(seg_amp)
    );

    assign com_oe = {NUM_COM{drive}};
    assign seg_oe = {SEG_PER_COM{drive}};
endmodule

// File: rtl/lcd_frame_seq_chk.sv
module lcd_frame_seq_chk
    import lcd_seq_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   tick,
    input logic [IDX_W-1:0]       duty,
    input logic                   drive_bypass,
    input logic [DT_W-1:0]        half_period,
    input logic                   supply_ok,
    input logic [NUM_COM-1:0]     com_amp,
    input logic [NUM_COM-1:0]     com_oe,
    input logic [SEG_PER_COM-1:0] seg_oe,
    input logic                   frame_start,
    input logic [NUM_BYTES*8-1:0] shadow
);
    logic [DT_W:0]        since_tick;
    logic [NUM_COM-1:0]   unused_mask;

    always_ff @(posedge clk) begin
        if (rst)
            since_tick <= '0;
        else if (tick)
            since_tick <= (DT_W+1)'(1);
        else if (since_tick != '1)
            since_tick <= since_tick + (DT_W+1)'(1);
    end

    always_comb
        for (int c = 0; c < NUM_COM; c++) unused_mask[c] = (IDX_W'(c) > duty);

    a_r1_frame_begins_com0: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> com_amp[0]);

    a_r2_single_address: assert property (@(posedge clk) disable iff (rst)
        $onehot0(com_amp));

    a_r5_shadow_hold: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(shadow));

    a_r7_on_time_cap: assert property (@(posedge clk) disable iff (rst)
        (duty != DUTY_STATIC && !drive_bypass && com_oe[0])
            |-> (since_tick <= {1'b0, half_period}));

    a_r9_supply_inhibit: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |-> (com_oe == '0 && seg_oe == '0));

    a_r10_unused_idle: assert property (@(posedge clk) disable iff (rst)
        (com_amp & unused_mask) == '0);
endmodule

bind lcd_frame_seq lcd_frame_seq_chk u_chk (.*);

// File: tb/lcd_frame_seq_bench.sv
module lcd_frame_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        tick = 1'b0;
    logic [1:0]  duty = 2'd3;
    logic [2:0]  drive_code = 3'd2;
    logic        drive_bypass = 1'b0;
    logic [7:0]  half_period = 8'd100;
    logic        supply_ok = 1'b1;
    logic [3:0]  com_phase, com_amp, com_oe;
    logic [39:0] seg_phase, seg_amp, seg_oe;

    int vectors = 0;
    int errors  = 0;

    lcd_frame_seq u_lcd_frame_seq (.*);

    always #2 clk = ~clk;

    function automatic logic [7:0] pat(int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    function automatic logic [39:0] grp_exp(int c);
        logic [39:0] g;
        for (int k = 0; k < 5; k++) g[k*8 +: 8] = pat(c * 5 + k);
        return g;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic write_byte(input int a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic write_all();
        for (int i = 0; i < 20; i++) write_byte(i, pat(i));
    endtask

    task automatic pulse_tick();
        tick = 1'b1; @(negedge clk); tick = 1'b0;
    endtask

    task automatic count_oe(input int n, output int k);
        k = 0;
        for (int i = 0; i < n; i++) begin
            if (seg_oe[0] && com_oe[0]) k++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        do_reset();
        check(com_oe == 0 && seg_oe == 0, "R11 oe", {com_oe, seg_oe}, 0);
        check(com_amp == 0 && seg_amp == 0, "R11 amp", {com_amp, seg_amp}, 0);
        check(com_phase == 0 && seg_phase == 0, "R11 phase", {com_phase, seg_phase}, 0);
    endtask

    task automatic t_supply();
        int k;
        duty = 2'd3; drive_code = 3'd7; supply_ok = 1'b0;
        do_reset(); write_all(); pulse_tick();
        count_oe(20, k);
        check(k == 0, "R9 inhibit", k, 0);
        supply_ok = 1'b1; @(negedge clk);
        check(seg_oe[39] == 1'b1, "R9 release", seg_oe[39], 1);
    endtask

    task automatic t_quarter_scan();
        int k;
        logic [3:0] cp;
        duty = 2'd3; drive_code = 3'd2; half_period = 8'd100;
        do_reset(); write_all();
        for (int c = 0; c < 4; c++) begin
            for (int h = 0; h < 2; h++) begin
                pulse_tick();
                for (int i = 0; i < 4; i++) cp[i] = (i == c) ? !h[0] : h[0];
                check(com_amp == 4'(1 << c), "R1 R2 addressed", com_amp, 4'(1 << c));
                check(com_phase == cp, "R2 com phase", com_phase, cp);
                check(seg_amp == grp_exp(c), "R4 seg data", seg_amp, grp_exp(c));
                check(seg_phase == (h[0] ? grp_exp(c) : ~grp_exp(c)), "R3 seg phase",
                      seg_phase, h[0] ? grp_exp(c) : ~grp_exp(c));
            end
        end
        pulse_tick();
        check(com_amp == 4'b0001, "R1 wrap", com_amp, 4'b0001);
        count_oe(12, k);
        check(k == 4, "R6 code2", k, 4);
        drive_code = 3'd0; pulse_tick();
        count_oe(12, k);
        check(k == 1, "R6 code0", k, 1);
    endtask

    task automatic t_shadow_half();
        duty = 2'd1; drive_code = 3'd1;
        do_reset(); write_all(); pulse_tick();
        write_byte(0, 8'h3C);
        check(seg_amp[7:0] == pat(0), "R5 held", seg_amp[7:0], pat(0));
        for (int s = 1; s < 4; s++) begin
            pulse_tick();
            check(com_amp[3:2] == 2'b00, "R10 unused amp", com_amp[3:2], 0);
            check(com_phase[3:2] == {2{s[0]}}, "R10 unused phase", com_phase[3:2], {2{s[0]}});
        end
        check(seg_amp == grp_exp(1), "R4 com1 group", seg_amp, grp_exp(1));
        pulse_tick();
        check(com_amp == 4'b0001, "R1 wrap half duty", com_amp, 4'b0001);
        check(seg_amp[7:0] == 8'h3C, "R5 new frame", seg_amp[7:0], 8'h3C);
    endtask

    task automatic t_cap_static();
        int k;
        duty = 2'd2; drive_code = 3'd7; half_period = 8'd10;
        do_reset(); write_all(); pulse_tick();
        count_oe(150, k);
        check(k == 10, "R7 clamp", k, 10);
        duty = 2'd0;
        do_reset(); write_all(); pulse_tick();
        count_oe(150, k);
        check(k == 128, "R7 static no clamp", k, 128);
        pulse_tick();
        check(com_amp == 4'b0001 && com_phase == 4'b1110, "R2 static half1",
              {com_amp, com_phase}, 8'h1E);
        check(seg_phase == grp_exp(0), "R3 static half1", seg_phase, grp_exp(0));
        pulse_tick();
        check(com_phase == 4'b0001, "R1 static wrap", com_phase, 4'b0001);
        check(seg_amp == grp_exp(0), "R4 static bytes", seg_amp, grp_exp(0));
    endtask

    task automatic t_bypass();
        int k;
        duty = 2'd3; drive_code = 3'd0; drive_bypass = 1'b1; half_period = 8'd2;
        do_reset(); write_all(); pulse_tick();
        count_oe(30, k);
        check(k == 30, "R8 bypass", k, 30);
        drive_bypass = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_supply();
        t_quarter_scan();
        t_shadow_half();
        t_cap_static();
        t_bypass();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule